// File: doc/BRIEF.md
# Inset Video Sync Processor

This block turns the horizontal and vertical sync of a secondary (inset) video channel into clean timing for the picture-in-picture path. Sync comes either from separate horizontal and vertical pins or from a combined three-level sync. The combined sync reaches the block as two comparator outputs: the low comparator marks horizontal pulses and the high comparator marks vertical pulses. All inputs are sampled on the 27 MHz clock. A source-select input chooses which pair drives the timing.

The horizontal edge is delayed by a programmable number of clocks, which centres the inset picture. Vertical pulses are qualified and then counted in lines. The count between two accepted pulses decides whether the source has 625 or 525 lines. Once the standard is locked, pulses that fall outside a window around the expected line are dropped as noise. The standard can also be forced. Each accepted vertical pulse is released as `vs_out` after a programmable number of lines. A field flag records whether the pulse fell in the first or the second half of its line. On the combined path the vertical pulse carries a fixed extra delay, so the same half-line test also works there.

Top module: `inset_sync_proc`

## Requirements
- R1: While `rst_n` is low, and after its release, `hs_out`, `vs_out`, `field_odd` and `std_locked` are 0. `is_625` is 1 when `auto_std` is 1.
- R2: With `src_comb`=0 the block uses `hs_sep`/`vs_sep` and ignores `cmp_h`/`cmp_v`. With `src_comb`=1 it uses `cmp_h`/`cmp_v` and ignores the separate pins.
- R3: A rising edge on the selected horizontal input, first seen at rising clock edge 1, gives a one-cycle `hs_out` pulse in the cycle after rising edge 3+`h_delay` (`h_delay` 0..255).
- R4: On the combined path, a vertical pulse is qualified only once `cmp_v` has been high for VMIN_CLKS consecutive samples. A shorter pulse produces no `vs_out`.
- R5: A qualified combined vertical pulse becomes a vertical event COMB_DLY clocks later (432 by default, about 16 µs). The field flag is decided at that delayed instant.
- R6: The line count between accepted vertical pulses is classed as 625-line within ±WIN of 312 and as 525-line within ±WIN of 262. `is_625` and `std_locked` change only when two consecutive accepted counts give the same class.
- R7: While locked in auto mode, or always in forced mode, a vertical pulse whose line count is more than WIN lines from the nominal count of the current standard is ignored. It produces no `vs_out` and does not restart the line count.
- R8: If the line count passes nominal+WIN with no accepted pulse, `std_locked` clears and the next vertical pulse is accepted whatever its count.
- R9: With `auto_std`=0, `is_625` equals `force_625` in the same cycle. With `auto_std`=1 it shows the detected standard.
- R10: `vs_out` is a one-cycle pulse that coincides with the (`v_delay`+1)-th `hs_out` pulse after an accepted vertical pulse (`v_delay` 0..15).
- R11: In the cycle after `vs_out`, `field_odd` becomes 1 if the accepted vertical event came at least HALF_LINE clocks after the last horizontal edge, and 0 otherwise. At other times it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_comb | input | 1 | 1 selects the combined-sync comparators, 0 the separate pins |
| hs_sep | input | 1 | Separate horizontal sync, active high |
| vs_sep | input | 1 | Separate vertical sync, active high |
| cmp_h | input | 1 | Combined sync, low-threshold comparator (horizontal) |
| cmp_v | input | 1 | Combined sync, high-threshold comparator (vertical) |
| auto_std | input | 1 | 1 enables automatic 625/525 detection |
| force_625 | input | 1 | Forced standard when `auto_std` is 0 (1 = 625) |
| h_delay | input | HDLY_W | Horizontal delay in clocks |
| v_delay | input | VDLY_W | Vertical delay in lines |
| hs_out | output | 1 | Delayed horizontal pulse |
| vs_out | output | 1 | Delayed, qualified vertical pulse |
| field_odd | output | 1 | Field flag, 1 = vertical event in the second half of a line |
| is_625 | output | 1 | Effective line standard, 1 = 625 lines |
| std_locked | output | 1 | Automatic detection has two agreeing fields |

## Verification
A wrong line count or lock state shows up at the ports within one field. A genuine vertical pulse then goes missing from `vs_out`, a noise pulse gets through, or `is_625`/`std_locked` flips at the wrong field boundary. A wrong position counter or combined-path delay shows up as a wrong `field_odd` in the cycle after the next `vs_out`. A wrong delay counter moves `hs_out` by whole clocks, or moves `vs_out` by whole lines, at its very next pulse.

// File: rtl/isp_pkg.sv
package isp_pkg;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_625  = 2'd1,
    CLS_525  = 2'd2
  } std_cls_e;

  // count lies within +/- win of nom
  function automatic logic near_nom(input logic [15:0] cnt, input logic [15:0] nom,
                                    input logic [15:0] win);
    return ((cnt + win) >= nom) && (cnt <= (nom + win));
  endfunction

  // count has run past the late edge of the window
  function automatic logic beyond_win(input logic [15:0] cnt, input logic [15:0] nom,
                                      input logic [15:0] win);
    return cnt > (nom + win);
  endfunction

  function automatic std_cls_e classify(input logic [15:0] cnt, input logic [15:0] n625,
                                        input logic [15:0] n525, input logic [15:0] win);
    if (near_nom(cnt, n625, win)) return CLS_625;
    if (near_nom(cnt, n525, win)) return CLS_525;
    return CLS_NONE;
  endfunction

endpackage

// File: rtl/isp_sync_front.sv
module isp_sync_front #(
  parameter int VMIN_CLKS = 81,
  parameter int COMB_DLY  = 432
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_comb,
  input  logic hs_sep,
  input  logic vs_sep,
  input  logic cmp_h,
  input  logic cmp_v,
  output logic h_evt,
  output logic v_evt
);
  localparam int VW_W = $clog2(VMIN_CLKS + 1);
  localparam int DW   = $clog2(COMB_DLY + 1);
  localparam logic [VW_W-1:0] VMIN_L = VW_W'(VMIN_CLKS);
  localparam logic [DW-1:0]   CDLY_L = DW'(COMB_DLY - 1);

  // bit order: {cmp_v, cmp_h, vs_sep, hs_sep}
  logic [3:0] s1, s2;
  logic [2:0] s3;
  logic [VW_W-1:0] wcnt;
  logic [DW-1:0]   dcnt;
  logic            dbusy;
  logic            h_lvl, h_lvl_d, v_sep_edge, comb_qual, comb_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= {cmp_v, cmp_h, vs_sep, hs_sep};
      s2 <= s1;
      s3 <= s2[2:0];
    end
  end

  assign h_lvl      = src_comb ? s2[2] : s2[0];
  assign h_lvl_d    = src_comb ? s3[2] : s3[0];
  assign h_evt      = h_lvl & ~h_lvl_d;
  assign v_sep_edge = s2[1] & ~s3[1];

  // width qualification of the high comparator
  assign comb_qual = s2[3] && (wcnt == VMIN_L - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= '0;
    end else if (!s2[3]) begin
      wcnt <= '0;
    end else if (wcnt != VMIN_L) begin
      wcnt <= wcnt + 1'b1;
    end
  end

  // fixed compensation delay of the combined vertical path
  assign comb_fire = dbusy && (dcnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbusy <= 1'b0;
      dcnt  <= '0;
    end else if (comb_qual) begin
      dbusy <= 1'b1;
      dcnt  <= CDLY_L;
    end else if (dbusy) begin
      if (dcnt == '0) dbusy <= 1'b0;
      else            dcnt  <= dcnt - 1'b1;
    end
  end

  assign v_evt = src_comb ? comb_fire : v_sep_edge;

  AST_VEVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    v_evt |=> !v_evt);  // R4

endmodule

// File: rtl/isp_hdelay.sv
module isp_hdelay #(
  parameter int HDLY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_evt,
  input  logic [HDLY_W-1:0] h_delay,
  output logic              hs_out
);
  logic [HDLY_W-1:0] cnt;
  logic              busy;

  assign hs_out = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (h_evt) begin
      busy <= 1'b1;
      cnt  <= h_delay;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  AST_HS_ZERO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (h_evt && (h_delay == '0)) |=> hs_out);  // R3

endmodule

// File: rtl/isp_std_detect.sv
module isp_std_detect
  import isp_pkg::*;
#(
  parameter int LCNT_W = 10,
  parameter int NOM625 = 312,
  parameter int NOM525 = 262,
  parameter int WIN    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic h_evt,
  input  logic v_evt,
  input  logic auto_en,
  input  logic force_625,
  output logic v_acc,
  output logic is_625,
  output logic std_locked
);
  logic [LCNT_W-1:0] line_cnt;
  logic              locked, hunt, det_625;
  std_cls_e          prev_cls, cur_cls;
  logic [15:0]       cnt16, nom16;
  logic              in_win, past_win, win_active;

  assign cnt16      = 16'(line_cnt);
  assign is_625     = auto_en ? det_625 : force_625;
  assign nom16      = is_625 ? 16'(NOM625) : 16'(NOM525);
  assign cur_cls    = classify(cnt16, 16'(NOM625), 16'(NOM525), 16'(WIN));
  assign in_win     = near_nom(cnt16, nom16, 16'(WIN));
  assign past_win   = beyond_win(cnt16, nom16, 16'(WIN));
  assign win_active = (auto_en ? locked : 1'b1) && !hunt;
  assign v_acc      = v_evt && (!win_active || in_win);
  assign std_locked = locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_cnt <= '0;
    end else if (v_acc) begin
      line_cnt <= '0;
    end else if (h_evt && (line_cnt != '1)) begin
      line_cnt <= line_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      hunt     <= 1'b0;
      det_625  <= 1'b1;
      prev_cls <= CLS_NONE;
    end else if (v_acc) begin
      hunt     <= 1'b0;
      prev_cls <= cur_cls;
      if ((cur_cls != CLS_NONE) && (cur_cls == prev_cls)) begin
        locked  <= 1'b1;
        det_625 <= (cur_cls == CLS_625);
      end
    end else if (past_win) begin
      hunt   <= 1'b1;
      locked <= 1'b0;
    end
  end

  AST_LOCK_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(v_acc));  // R6
  AST_STD_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(det_625) |-> $past(v_acc));  // R6
  AST_IGNORED_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (v_evt && !v_acc && !h_evt) |=> $stable(line_cnt));  // R7
  AST_HUNT_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hunt) |-> !locked);  // R8

endmodule

// File: rtl/isp_vphase.sv
module isp_vphase #(
  parameter int HALF_LINE = 864,
  parameter int VDLY_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_evt,
  input  logic              hs_out,
  input  logic              v_acc,
  input  logic [VDLY_W-1:0] v_delay,
  output logic              vs_out,
  output logic              field_odd
);
  localparam int POS_W = $clog2(2 * HALF_LINE);
  localparam logic [POS_W-1:0] HALF_L = POS_W'(HALF_LINE);

  logic [POS_W-1:0]  pos;
  logic [VDLY_W-1:0] left;
  logic              pend, fld_cap;

  always_ff @(posedge clk) begin
    if (!rst_n)               pos <= '0;
    else if (h_evt)           pos <= '0;
    else if (pos != '1)       pos <= pos + 1'b1;
  end

  assign vs_out = pend && hs_out && (left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      left    <= '0;
      fld_cap <= 1'b0;
    end else if (v_acc) begin
      pend    <= 1'b1;
      left    <= v_delay;
      fld_cap <= (pos >= HALF_L);
    end else if (pend && hs_out) begin
      if (left == '0) pend <= 1'b0;
      else            left <= left - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      field_odd <= 1'b0;
    else if (vs_out) field_odd <= fld_cap;
  end

  AST_VS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    vs_out |=> !vs_out);  // R10
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(vs_out) |-> $stable(field_odd));  // R11

endmodule

// File: rtl/inset_sync_proc.sv
module inset_sync_proc #(
  parameter int HDLY_W    = 8,
  parameter int VDLY_W    = 4,
  parameter int HALF_LINE = 864,
  parameter int VMIN_CLKS = 81,
  parameter int COMB_DLY  = 432,
  parameter int LCNT_W    = 10,
  parameter int NOM625    = 312,
  parameter int NOM525    = 262,
  parameter int WIN       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_comb,
  input  logic              hs_sep,
  input  logic              vs_sep,
  input  logic              cmp_h,
  input  logic              cmp_v,
  input  logic              auto_std,
  input  logic              force_625,
  input  logic [HDLY_W-1:0] h_delay,
  input  logic [VDLY_W-1:0] v_delay,
  output logic              hs_out,
  output logic              vs_out,
  output logic              field_odd,
  output logic              is_625,
  output logic              std_locked
);
  logic h_evt, v_evt, v_acc;

  isp_sync_front #(.VMIN_CLKS(VMIN_CLKS), .COMB_DLY(COMB_DLY)) u_front (
    .clk(clk), .rst_n(rst_n), .src_comb(src_comb),
    .hs_sep(hs_sep), .vs_sep(vs_sep), .cmp_h(cmp_h), .cmp_v(cmp_v),
    .h_evt(h_evt), .v_evt(v_evt)
  );

  isp_hdelay #(.HDLY_W(HDLY_W)) u_hdly (
    .clk(clk), .rst_n(rst_n), .h_evt(h_evt), .h_delay(h_delay), .hs_out(hs_out)
  );

  isp_std_detect #(.LCNT_W(LCNT_W), .NOM625(NOM625), .NOM525(NOM525), .WIN(WIN)) u_std (
    .clk(clk), .rst_n(rst_n), .h_evt(h_evt), .v_evt(v_evt),
    .auto_en(auto_std), .force_625(force_625),
    .v_acc(v_acc), .is_625(is_625), .std_locked(std_locked)
  );

  isp_vphase #(.HALF_LINE(HALF_LINE), .VDLY_W(VDLY_W)) u_vph (
    .clk(clk), .rst_n(rst_n), .h_evt(h_evt), .hs_out(hs_out), .v_acc(v_acc),
    .v_delay(v_delay), .vs_out(vs_out), .field_odd(field_odd)
  );

endmodule

// File: tb/test_inset_sync_proc.sv
`timescale 1ns/1ps
module test_inset_sync_proc;
  localparam int LINE = 24;
  localparam int HALF = 12;
  localparam int VMIN = 3;
  localparam int CDLY = 9;

  logic clk = 1'b0;
  logic rst_n, src_comb, hs_sep, vs_sep, cmp_h, cmp_v, auto_std, force_625;
  logic [7:0] h_delay;
  logic [3:0] v_delay;
  logic hs_out, vs_out, field_odd, is_625, std_locked;

  int checks = 0, errors = 0;
  int hs_since = 0, vs_seen = 0, vdel = 0;
  bit exp_odd = 0, field_due = 0, done = 0;
  string fld_req = "R11";

  always #2.5 clk = ~clk;

  inset_sync_proc #(.HALF_LINE(HALF), .VMIN_CLKS(VMIN), .COMB_DLY(CDLY)) i_inset_sync_proc (
    .clk(clk), .rst_n(rst_n), .src_comb(src_comb), .hs_sep(hs_sep), .vs_sep(vs_sep),
    .cmp_h(cmp_h), .cmp_v(cmp_v), .auto_std(auto_std), .force_625(force_625),
    .h_delay(h_delay), .v_delay(v_delay), .hs_out(hs_out), .vs_out(vs_out),
    .field_odd(field_odd), .is_625(is_625), .std_locked(std_locked)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // clock position of the accepted vertical event within its line
  function automatic bit exp_field(input bit comb, input int vpos);
    int p;
    p = comb ? (vpos - 1) + (VMIN - 1) + CDLY : vpos - 1;
    return p >= HALF;
  endfunction

  task automatic run_line(input bit vhere, input int vpos, input int vlen);
    for (int p = 0; p < LINE; p++) begin
      logic vl;
      @(negedge clk);
      if (field_due) begin
        chk(field_odd == exp_odd, fld_req, field_odd, exp_odd);
        field_due = 0;
      end
      if (hs_out) hs_since++;
      if (vs_out) begin
        vs_seen++;
        chk(hs_since == vdel + 1, "R10", hs_since, vdel + 1);
        field_due = 1;
      end
      hs_sep = (p < 2);
      cmp_h  = (p < 2);
      if (vhere && p == vpos) begin
        hs_since = 0;
        exp_odd  = exp_field(src_comb, vpos);
      end
      vl = vhere && (p >= vpos) && (p < vpos + vlen);
      vs_sep = vl;
      cmp_v  = vl;
    end
  endtask

  task automatic run_field(input int n, input int vpos, input int vlen, input int spur,
                           input int exp_vs, input string req);
    vs_seen = 0;
    for (int l = 0; l < n; l++) run_line((l == 0) || (l == spur), vpos, vlen);
    chk(vs_seen == exp_vs, req, vs_seen, exp_vs);
  endtask

  task automatic h_trial(input int d, input bit comb, input bit wrong, output int lat);
    h_delay  = 8'(d);
    src_comb = comb;
    @(negedge clk);
    if (comb ^ wrong) cmp_h = 1'b1; else hs_sep = 1'b1;
    lat = -1;
    for (int i = 1; i <= 300; i++) begin
      @(negedge clk);
      if (i == 2) begin hs_sep = 1'b0; cmp_h = 1'b0; end
      if (hs_out && lat < 0) lat = i;
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int lat, d;
    void'($urandom(32'd4242));
    rst_n = 0; src_comb = 0; hs_sep = 0; vs_sep = 0; cmp_h = 0; cmp_v = 0;
    auto_std = 1; force_625 = 0; h_delay = 0; v_delay = 0;
    repeat (5) @(negedge clk);
    chk(hs_out == 0 && vs_out == 0, "R1", {hs_out, vs_out}, 0);
    chk(field_odd == 0 && std_locked == 0, "R1", {field_odd, std_locked}, 0);
    chk(is_625 == 1, "R1", is_625, 1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(hs_out == 0 && std_locked == 0, "R1", {hs_out, std_locked}, 0);

    // R3 horizontal delay: corners then random
    h_trial(0, 0, 0, lat);   chk(lat == 3, "R3", lat, 3);
    h_trial(255, 0, 0, lat); chk(lat == 258, "R3", lat, 258);
    for (int k = 0; k < 5; k++) begin
      d = int'($urandom % 256);
      h_trial(d, 0, 0, lat); chk(lat == 3 + d, "R3", lat, 3 + d);
    end
    d = int'($urandom % 256);
    h_trial(d, 1, 0, lat); chk(lat == 3 + d, "R2", lat, 3 + d);
    h_trial(5, 1, 1, lat); chk(lat == -1, "R2", lat, -1);
    h_trial(5, 0, 1, lat); chk(lat == -1, "R2", lat, -1);

    // 625-line source on separate pins, alternating field phase
    h_delay = 0; src_comb = 0;
    v_delay = 4'($urandom % 16); vdel = int'(v_delay);
    run_field(312, 6, 4, -1, 1, "R10");
    run_field(313, 18, 4, -1, 1, "R10");
    chk(std_locked == 0, "R6", std_locked, 0);
    run_field(312, 6, 4, -1, 1, "R10");
    run_field(313, 18, 4, -1, 1, "R10");
    chk(std_locked == 1, "R6", std_locked, 1);
    chk(is_625 == 1, "R6", is_625, 1);
    // spurious vertical pulse in mid-field
    run_field(312, 6, 4, 100, 1, "R7");

    // source switches to 525 lines
    run_field(262, 6, 4, -1, 1, "R10");
    run_field(263, 18, 4, -1, 0, "R7");
    chk(std_locked == 0, "R8", std_locked, 0);
    run_field(262, 6, 4, -1, 1, "R8");
    run_field(263, 18, 4, -1, 1, "R10");
    run_field(262, 6, 4, -1, 1, "R10");
    chk(std_locked == 1 && is_625 == 0, "R6", {std_locked, is_625}, 2);
    run_field(263, 18, 4, -1, 1, "R10");

    // forced standard
    auto_std = 0; force_625 = 1;
    @(negedge clk); chk(is_625 == 1, "R9", is_625, 1);
    force_625 = 0;
    @(negedge clk); chk(is_625 == 0, "R9", is_625, 0);
    force_625 = 1; auto_std = 1;
    @(negedge clk); chk(is_625 == 0, "R9", is_625, 0);
    force_625 = 0;

    // combined path: delay moves an early-line pulse into the second half
    src_comb = 1; fld_req = "R5";
    v_delay = 4'($urandom % 16); vdel = int'(v_delay);
    chk(exp_field(1, 6) == 1, "R5", exp_field(1, 6), 1);
    run_field(262, 6, 6, -1, 1, "R2");
    run_field(263, 6, 6, -1, 1, "R2");
    run_field(262, 6, 6, -1, 1, "R5");
    // too-short high comparator pulse
    run_field(40, 6, 2, -1, 0, "R4");

    done = 1;
    finish_run();
  end
endmodule